// File: doc/BRIEF.md
# Workspace-Register Add Sequencer

This block is a slice of a small processor datapath. The only state it keeps on chip is a program counter, two status flags (carry and zero) and a workspace pointer. The sixteen general registers are not flip-flops. They sit in ordinary external word memory, starting at the byte address held in the workspace pointer. Every register operand therefore costs a real bus cycle on the memory port.

On a start pulse the block runs one register-to-register add as a fixed schedule of seven machine cycles. Each machine cycle lasts two clocks, and memory and internal cycles alternate:

1. fetch
2. decode
3. read first register
4. setup
5. read second register
6. add
7. write result

The sum is stored back into the first register's memory word as part of the same instruction.

While the block is idle, a load strobe replaces the workspace pointer. All register accesses after that use the new base, so a context switch needs no register copying.

Top module: `wsreg_seq`

## Requirements
- R1: After reset, `pc_out` equals RESET_PC (default 0x0100) and `wp_out` equals RESET_WP (default 0x0200). Both flags are 0, and `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: A start seen while idle makes `busy` high for exactly 14 clocks (7 machine cycles × 2 clocks). `done` is high only in the 14th of those clocks, which is the second clock of the write cycle.
- R3: Strobes follow the machine cycle:
  - `mem_rd` is asserted in machine cycles 0, 2 and 4, and `mem_wr` in machine cycle 6, each for both clocks of the cycle with `mem_addr` held stable.
  - Neither strobe is asserted in machine cycles 1, 3 and 5 or while idle.
  - The two strobes are never high together.
- R4: The instruction is fetched from byte address `pc_out`. The PC then advances by 2, and it does not change while idle.
- R5: Register n sits at byte address WP + 2·n. Fetched word bits [7:4] select the first register, read in machine cycle 2. Bits [3:0] select the second register, read in machine cycle 4.
- R6: In machine cycle 6 the 16-bit sum (mod 2^16) of the two operands is written to the first register's address. This holds even when both fields name the same register.
- R7: The carry flag becomes bit 16 of the 17-bit sum, and the zero flag is set exactly when the 16-bit result is zero. Both are visible from the write cycle onward.
- R8: WP loading:
  - `ld_wp` while idle loads `wp_in` into the workspace pointer on the next edge.
  - If it arrives together with start, that instruction already uses the new base.
  - `ld_wp` while busy has no effect.
- R9: A start asserted while busy is ignored and does not begin a second instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one add instruction when idle |
| ld_wp | input | 1 | Load workspace pointer from `wp_in` when idle |
| wp_in | input | 16 | New workspace base (byte address) |
| mem_rdata | input | 16 | Read data, valid in the second clock of a read cycle |
| mem_addr | output | 16 | Byte address of the current memory cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the sum) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last clock of the write cycle |
| pc_out | output | 16 | Program counter |
| wp_out | output | 16 | Workspace pointer |
| st_c | output | 1 | Carry flag |
| st_z | output | 1 | Zero flag |

## Verification
The add is run with the following operand patterns:
- Small values with no carry.
- A pair that wraps to zero, which sets both flags.
- A pair that carries to a non-zero result, which separates the carry path from the zero path.
- Both fields naming the same register, which exposes a wrong write-back target or operand order.

The register fields R0 and R15 probe the end offsets WP+0 and WP+30.

For the workspace pointer, three patterns are tried:
- A load while idle, checked by reading a word in the old workspace afterwards, which must be untouched.
- A load in the same cycle as start.
- A load and a start both arriving mid-instruction.

Together these separate an honoured base change from an ignored one.

// File: rtl/wsseq_pkg.sv
// Shared types for the workspace-register add sequencer.
// Assumes a fixed seven-machine-cycle schedule; even cycles touch memory.
package wsseq_pkg;

    typedef enum logic [2:0] {
        MC_FETCH  = 3'd0,
        MC_DECODE = 3'd1,
        MC_RDA    = 3'd2,
        MC_SETUP  = 3'd3,
        MC_RDB    = 3'd4,
        MC_ADD    = 3'd5,
        MC_WRITE  = 3'd6
    } mcyc_e;

endpackage

// File: rtl/wsseq_timer.sv
// Machine-cycle timer: walks MC_FETCH..MC_WRITE, CLK_PER_MC clocks each.
// Assumes start is ignored while an instruction is running.
module wsseq_timer
    import wsseq_pkg::*;
#(
    parameter int CLK_PER_MC = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output logic  busy,
    output mcyc_e mc,
    output logic  last_clk,
    output logic  done
);
    localparam int SUB_W = (CLK_PER_MC > 1) ? $clog2(CLK_PER_MC) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_MC - 1);

    logic [SUB_W-1:0] sub_q;

    // Purpose: advance the sub-clock and machine-cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sub_q <= '0;
            mc    <= MC_FETCH;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                sub_q <= '0;
                mc    <= MC_FETCH;
            end
        end else if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (mc == MC_WRITE) begin
                busy <= 1'b0;
                mc   <= MC_FETCH;
            end else begin
                mc <= mcyc_e'(mc + 3'd1);
            end
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

    // Purpose: flag the final clock of a machine cycle and of the instruction.
    always_comb begin
        last_clk = busy && (sub_q == SUB_LAST);
        done     = last_clk && (mc == MC_WRITE);
    end

endmodule

// File: rtl/wsseq_agen.sv
// Address and strobe generator: maps the machine cycle to a bus access.
// Assumes register n lives at WP + n * (DW/8) bytes.
module wsseq_agen
    import wsseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int RIDX_W = 4
) (
    input  logic              busy,
    input  mcyc_e             mc,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     wp,
    input  logic [RIDX_W-1:0] ra,
    input  logic [RIDX_W-1:0] rb,
    output logic [AW-1:0]     addr,
    output logic              rd,
    output logic              wr
);
    localparam int BYTES = DW / 8;
    localparam int SHIFT = (BYTES > 1) ? $clog2(BYTES) : 0;

    logic [AW-1:0] a_addr;
    logic [AW-1:0] b_addr;

    // Purpose: workspace byte addresses of both register operands.
    always_comb begin
        a_addr = wp + (AW'(ra) << SHIFT);
        b_addr = wp + (AW'(rb) << SHIFT);
    end

    // Purpose: select address and strobe for the current machine cycle.
    always_comb begin
        addr = '0;
        rd   = 1'b0;
        wr   = 1'b0;
        if (busy) begin
            case (mc)
                MC_FETCH: begin addr = pc;     rd = 1'b1; end
                MC_RDA:   begin addr = a_addr; rd = 1'b1; end
                MC_RDB:   begin addr = b_addr; rd = 1'b1; end
                MC_WRITE: begin addr = a_addr; wr = 1'b1; end
                default:  begin addr = '0; end
            endcase
        end
    end

endmodule

// File: rtl/wsseq_adder.sv
// Word adder with carry-out and zero detect.
// Assumes unsigned operands of DW bits.
module wsseq_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          zero
);
    logic [DW:0] full;

    // Purpose: form the extended sum and its flags.
    always_comb begin
        full  = {1'b0, a} + {1'b0, b};
        sum   = full[DW-1:0];
        carry = full[DW];
        zero  = (full[DW-1:0] == '0);
    end

endmodule

// File: rtl/wsreg_seq.sv
// Workspace-register add sequencer top. On-chip state: PC, WP, flags.
// General registers live in external memory at WP + 2n.
// Assumes memory returns read data in the second clock of a read cycle.
module wsreg_seq
    import wsseq_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          NREG       = 16,
    parameter int          CLK_PER_MC = 2,
    parameter logic [15:0] RESET_PC   = 16'h0100,
    parameter logic [15:0] RESET_WP   = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ld_wp,
    input  logic [AW-1:0] wp_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] wp_out,
    output logic          st_c,
    output logic          st_z
);
    localparam int            RIDX_W  = $clog2(NREG);
    localparam int            FIELD_W = 2 * RIDX_W;
    localparam logic [AW-1:0] PC_STEP = AW'(DW / 8);

    mcyc_e               mc;
    logic                last_clk;
    logic [AW-1:0]       pc_q;
    logic [AW-1:0]       wp_q;
    logic [FIELD_W-1:0]  ir_q;
    logic [DW-1:0]       opa_q;
    logic [DW-1:0]       opb_q;
    logic [DW-1:0]       res_q;
    logic                c_q;
    logic                z_q;
    logic [DW-1:0]       sum;
    logic                sum_c;
    logic                sum_z;
    logic [RIDX_W-1:0]   ra;
    logic [RIDX_W-1:0]   rb;

    wsseq_timer #(.CLK_PER_MC(CLK_PER_MC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .mc       (mc),
        .last_clk (last_clk),
        .done     (done)
    );

    // Purpose: split the captured instruction into the two register fields.
    always_comb begin
        ra = ir_q[FIELD_W-1:RIDX_W];
        rb = ir_q[RIDX_W-1:0];
    end

    wsseq_agen #(.AW(AW), .DW(DW), .RIDX_W(RIDX_W)) u_agen (
        .busy (busy),
        .mc   (mc),
        .pc   (pc_q),
        .wp   (wp_q),
        .ra   (ra),
        .rb   (rb),
        .addr (mem_addr),
        .rd   (mem_rd),
        .wr   (mem_wr)
    );

    wsseq_adder #(.DW(DW)) u_add (
        .a     (opa_q),
        .b     (opb_q),
        .sum   (sum),
        .carry (sum_c),
        .zero  (sum_z)
    );

    // Purpose: workspace pointer, reloadable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= AW'(RESET_WP);
        end else if (ld_wp && !busy) begin
            wp_q <= wp_in;
        end
    end

    // Purpose: capture bus data and results at the end of each machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= AW'(RESET_PC);
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (last_clk) begin
            case (mc)
                MC_FETCH: begin
                    ir_q <= mem_rdata[FIELD_W-1:0];
                    pc_q <= pc_q + PC_STEP;
                end
                MC_RDA: opa_q <= mem_rdata;
                MC_RDB: opb_q <= mem_rdata;
                MC_ADD: begin
                    res_q <= sum;
                    c_q   <= sum_c;
                    z_q   <= sum_z;
                end
                default: ;
            endcase
        end
    end

    // Purpose: drive the architectural outputs.
    always_comb begin
        mem_wdata = res_q;
        pc_out    = pc_q;
        wp_out    = wp_q;
        st_c      = c_q;
        st_z      = z_q;
    end

endmodule

// File: rtl/wsreg_seq_chk.sv
// Protocol checker for wsreg_seq, attached by bind.
// Assumes synchronous active-low reset.
module wsreg_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_wp,
    input logic [AW-1:0] wp_in,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] pc_out,
    input logic [AW-1:0] wp_out,
    input logic          st_z
);
    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> (mem_rd && $stable(mem_addr)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |=> (mem_wr && $stable(mem_addr)));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R2
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2
    done_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_wr);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (st_z == (mem_wdata == '0)));

    // R8
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wp_out));

    // R8
    wp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wp && !busy) |=> (wp_out == $past(wp_in)));

    // R4
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(pc_out));

endmodule

bind wsreg_seq wsreg_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_wp     (ld_wp),
    .wp_in     (wp_in),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .pc_out    (pc_out),
    .wp_out    (wp_out),
    .st_z      (st_z)
);

// File: tb/sim_wsreg_seq.sv
// Directed bench for wsreg_seq with a registered-read word memory model.
module sim_wsreg_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        ld_wp;
    logic [15:0] wp_in;
    logic [15:0] mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [15:0] wp_out;
    logic        st_c;
    logic        st_z;

    logic [15:0] mem [512];
    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] exp_pc;
    logic [15:0] exp_wp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wsreg_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ld_wp     (ld_wp),
        .wp_in     (wp_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .pc_out    (pc_out),
        .wp_out    (wp_out),
        .st_c      (st_c),
        .st_z      (st_z)
    );

    // memory model: write on strobe, read data registered one clock later
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:1]];
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one add instruction with cycle-by-cycle bus checks
    task automatic run_add(input logic [3:0] a, input logic [3:0] b,
                           input logic [15:0] va, input logic [15:0] vb,
                           input bit ldwp_now, input logic [15:0] nwp,
                           input bit poke);
        logic [15:0] opa, opb, res, fetch_pc, a_adr, b_adr;
        logic [16:0] full;
        if (ldwp_now) exp_wp = nwp;
        a_adr = exp_wp + {11'd0, a, 1'b0};
        b_adr = exp_wp + {11'd0, b, 1'b0};
        mem[exp_pc[9:1]] = {8'h00, a, b};
        mem[a_adr[9:1]]  = va;
        mem[b_adr[9:1]]  = vb;
        opa = mem[a_adr[9:1]];
        opb = mem[b_adr[9:1]];
        full = {1'b0, opa} + {1'b0, opb};
        res = full[15:0];
        fetch_pc = exp_pc;
        @(negedge clk);
        start = 1'b1;
        if (ldwp_now) begin ld_wp = 1'b1; wp_in = nwp; end
        @(negedge clk);
        start = 1'b0;
        ld_wp = 1'b0;
        for (int k = 0; k < 14; k++) begin
            int m;
            m = k / 2;
            chk(busy == 1'b1, "R2 busy in instruction", {31'd0, busy}, 32'd1);
            chk(done == (k == 13), "R2 done timing", {31'd0, done}, {31'd0, k == 13});
            chk(mem_rd == (m == 0 || m == 2 || m == 4), "R3 read strobe",
                {31'd0, mem_rd}, {31'd0, m == 0 || m == 2 || m == 4});
            chk(mem_wr == (m == 6), "R3 write strobe", {31'd0, mem_wr}, {31'd0, m == 6});
            if (m == 0) chk(mem_addr == fetch_pc, "R4 fetch address", {16'd0, mem_addr}, {16'd0, fetch_pc});
            if (m == 2) chk(mem_addr == a_adr, "R5 first reg address", {16'd0, mem_addr}, {16'd0, a_adr});
            if (m == 4) chk(mem_addr == b_adr, "R5 second reg address", {16'd0, mem_addr}, {16'd0, b_adr});
            if (m == 6) begin
                chk(mem_addr == a_adr, "R6 write address", {16'd0, mem_addr}, {16'd0, a_adr});
                chk(mem_wdata == res, "R6 write data", {16'd0, mem_wdata}, {16'd0, res});
            end
            if (poke && k == 5) begin start = 1'b1; ld_wp = 1'b1; wp_in = 16'h01F0; end
            if (poke && k == 6) begin start = 1'b0; ld_wp = 1'b0; end
            @(negedge clk);
        end
        exp_pc = fetch_pc + 16'd2;
        chk(busy == 1'b0, "R2 busy drops after 14 clocks", {31'd0, busy}, 32'd0);
        chk(pc_out == exp_pc, "R4 pc advance", {16'd0, pc_out}, {16'd0, exp_pc});
        chk(wp_out == exp_wp, "R8 wp value", {16'd0, wp_out}, {16'd0, exp_wp});
        chk(st_c == full[16], "R7 carry", {31'd0, st_c}, {31'd0, full[16]});
        chk(st_z == (res == 16'd0), "R7 zero", {31'd0, st_z}, {31'd0, res == 16'd0});
        chk(mem[a_adr[9:1]] == res, "R6 memory result", {16'd0, mem[a_adr[9:1]]}, {16'd0, res});
    endtask

    task automatic t_reset();
        chk(pc_out == 16'h0100, "R1 reset pc", {16'd0, pc_out}, 32'h0100);
        chk(wp_out == 16'h0200, "R1 reset wp", {16'd0, wp_out}, 32'h0200);
        chk(!st_c && !st_z, "R1 reset flags", {30'd0, st_c, st_z}, 32'd0);
        chk(!busy && !done, "R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk(!mem_rd && !mem_wr, "R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    endtask

    task automatic t_ldwp_idle();
        mem[(16'h0200 >> 1) + 2] = 16'hBEEF;
        @(negedge clk);
        ld_wp = 1'b1;
        wp_in = 16'h0300;
        @(negedge clk);
        ld_wp = 1'b0;
        exp_wp = 16'h0300;
        chk(wp_out == 16'h0300, "R8 idle wp load", {16'd0, wp_out}, 32'h0300);
        run_add(4'd2, 4'd5, 16'h1111, 16'h2222, 1'b0, 16'h0, 1'b0);
        chk(mem[(16'h0200 >> 1) + 2] == 16'hBEEF, "R8 old workspace untouched",
            {16'd0, mem[(16'h0200 >> 1) + 2]}, 32'hBEEF);
    endtask

    task automatic t_busy_poke();
        run_add(4'd6, 4'd7, 16'h0003, 16'h0004, 1'b0, 16'h0, 1'b1);
        @(negedge clk);
        chk(busy == 1'b0, "R9 start while busy ignored", {31'd0, busy}, 32'd0);
        chk(wp_out == exp_wp, "R8 wp load while busy ignored", {16'd0, wp_out}, {16'd0, exp_wp});
        chk(pc_out == exp_pc, "R9 no second fetch", {16'd0, pc_out}, {16'd0, exp_pc});
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
        rst_n = 1'b0; start = 1'b0; ld_wp = 1'b0; wp_in = 16'h0000;
        exp_pc = 16'h0100; exp_wp = 16'h0200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_add(4'd1, 4'd2, 16'd5, 16'd7, 1'b0, 16'h0, 1'b0);           // basic
        run_add(4'd4, 4'd9, 16'hFFFF, 16'h0001, 1'b0, 16'h0, 1'b0);     // carry + zero
        run_add(4'd15, 4'd0, 16'h8000, 16'h9000, 1'b0, 16'h0, 1'b0);    // carry, non-zero, end regs
        run_add(4'd3, 4'd3, 16'h4321, 16'h4321, 1'b0, 16'h0, 1'b0);     // same register
        t_ldwp_idle();
        run_add(4'd8, 4'd1, 16'h0100, 16'h0023, 1'b1, 16'h0380, 1'b0); // load with start
        t_busy_poke();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule